// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block puts a small window of four 16-bit registers in front of a slave device whose own address space is far wider than the window. The host writes a high address word, a low address word and, for a write, a data word. It then writes a command word into the control register. The bridge builds the full downstream address from these pieces and places a single request on a downstream request/acknowledge bus. While an indirect command is outstanding it reports busy in the control register. When a read completes, the returned word is stored in the data register for the host to collect.

The command word uses fixed bit patterns. Address bits 3:1 of the target ride in control bits 11:9, and those bits are left out when the pattern is decoded. An indirect read and an indirect write show busy. A direct write uses the same downstream handshake but never shows busy, because the host is not expected to poll for it. Bit 0 of the control register reflects the presence input, so an idle bridge in front of a present slave reads back 0x0001.

Downstream back-pressure works as follows. Once `dn_valid` is raised, the bridge keeps `dn_valid`, `dn_write`, `dn_addr` and `dn_wdata` constant until it samples `dn_ready` high on a rising clock edge. That edge completes the transfer. There is no hardware timeout; the slave may hold `dn_ready` low for as long as it needs.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the data, high-address and low-address registers read 0 and `dn_valid` is low. The control register reads bit 0 equal to `slv_present` and every other bit 0 (0x0001 when present, 0x0000 when not).
- R2: Host writes go to the data register at offset 0x4, the high-address register at offset 0x8 and the low-address register at offset 0xA. All three read back what was written, except that the high-address register keeps only its low 12 bits; bits 15:12 read as 0.
- R3: When the control register (offset 0x0) is written with a word whose bits other than 11:9 equal 0x0101, the bridge starts an indirect read. From the next cycle `dn_valid` is 1, `dn_write` is 0, and `dn_addr` (target address bits 31:1) equals {high[11:0], low[15:0], control[11:9]}.
- R4: When the control word, with bits 11:9 masked out, equals 0x3101, the bridge starts an indirect write. The address is built as in R3, `dn_write` is 1 and `dn_wdata` equals the data register.
- R5: Control bit 8 reads 1 from the cycle after an indirect command is accepted until the edge where `dn_ready` is seen. On that same edge, for a read, `dn_rdata` is stored in the data register, so the value is readable as soon as bit 8 reads 0. Bit 8 is never 1 while `dn_valid` is low.
- R6: When the control word, with bits 11:9 masked out, equals 0x3001, the bridge starts a direct write. It issues a downstream write like R4, but control bit 8 stays 0 throughout.
- R7: While `dn_valid` is high and `dn_ready` is low, `dn_valid`, `dn_write`, `dn_addr` and `dn_wdata` hold their values into the next cycle.
- R8: A control write made while a request is outstanding is ignored. It neither changes the current request nor starts another after the current one completes.
- R9: A control write whose word does not match any of the three command patterns starts no request.
- R10: A data register write made while a request is outstanding is ignored. `dn_wdata` and the data register keep their earlier value.
- R11: Address register writes made while a request is outstanding take effect in the registers, but they do not change `dn_addr` of the outstanding request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| slv_present | input | 1 | Slave present, shown in control bit 0 |
| hst_we | input | 1 | Host write strobe, one cycle per write |
| hst_addr | input | 4 | Host byte offset in the window (0x0, 0x4, 0x8, 0xA) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data for `hst_addr`, combinational |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream acknowledge; completes the request |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | 31 | Downstream target address bits 31:1 |
| dn_wdata | output | 16 | Downstream write data |
| dn_rdata | input | 16 | Downstream read data, sampled with `dn_ready` |

## Verification
The command path is driven with random high and low address words, random sub-word bits 11:9, random data words and a random acknowledge latency of 0 to 5 cycles, across all three command kinds. A wrong field placement in the built address, or a swap of the read and write direction, therefore shows up quickly. The zero-latency case separates an acknowledge taken on the first valid cycle from one that arrives late, and the direct write is the only pattern that tells whether busy is shown for the right kinds. Directed sequences issue control, data and address writes during an outstanding request, plus near-miss command words, to show that requests are neither altered nor queued.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int REG_W = 16;
  localparam int SUB_W = 3;
  localparam int SUB_LSB = 9;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_DWR  = 2'd3
  } irb_cmd_e;

  localparam logic [REG_W-1:0] CMD_MASK = 16'hF1FF;
  localparam logic [REG_W-1:0] PAT_RD   = 16'h0101;
  localparam logic [REG_W-1:0] PAT_WR   = 16'h3101;
  localparam logic [REG_W-1:0] PAT_DWR  = 16'h3001;

  localparam logic [3:0] OFS_CTL = 4'h0;
  localparam logic [3:0] OFS_DAT = 4'h4;
  localparam logic [3:0] OFS_HI  = 4'h8;
  localparam logic [3:0] OFS_LO  = 4'hA;
endpackage

// File: rtl/irb_cmd_dec.sv
module irb_cmd_dec
  import irb_pkg::*;
(
  input  logic [REG_W-1:0] ctl_word,
  output irb_cmd_e         cmd,
  output logic [SUB_W-1:0] sub_addr
);
  logic [REG_W-1:0] masked;

  always_comb begin
    masked = ctl_word & CMD_MASK;
    unique case (masked)
      PAT_RD:  cmd = CMD_RD;
      PAT_WR:  cmd = CMD_WR;
      PAT_DWR: cmd = CMD_DWR;
      default: cmd = CMD_NONE;
    endcase
    sub_addr = ctl_word[SUB_LSB +: SUB_W];
  end
endmodule

// File: rtl/irb_regs.sv
module irb_regs
  import irb_pkg::*;
#(
  parameter int HI_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_ofs,
  input  logic [REG_W-1:0] wr_data,
  input  logic             xfer_active,
  input  logic             cap_en,
  input  logic [REG_W-1:0] cap_data,
  output logic [REG_W-1:0] data_q,
  output logic [HI_W-1:0]  hi_q,
  output logic [REG_W-1:0] lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (cap_en) begin
        data_q <= cap_data;
      end else if (wr_en && wr_ofs == OFS_DAT && !xfer_active) begin
        data_q <= wr_data;
      end
      if (wr_en && wr_ofs == OFS_HI) hi_q <= wr_data[HI_W-1:0];
      if (wr_en && wr_ofs == OFS_LO) lo_q <= wr_data;
    end
  end
endmodule

// File: rtl/irb_xfer.sv
module irb_xfer
  import irb_pkg::*;
#(
  parameter int AW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  irb_cmd_e      cmd,
  input  logic [AW-1:0] addr_in,
  input  logic          dn_ready,
  output logic          dn_valid,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic          busy_vis,
  output logic          rd_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_write <= 1'b0;
      dn_addr  <= '0;
      busy_vis <= 1'b0;
    end else if (!dn_valid) begin
      if (start && cmd != CMD_NONE) begin
        dn_valid <= 1'b1;
        dn_write <= (cmd != CMD_RD);
        dn_addr  <= addr_in;
        busy_vis <= (cmd != CMD_DWR);
      end
    end else if (dn_ready) begin
      dn_valid <= 1'b0;
      busy_vis <= 1'b0;
    end
  end

  assign rd_done = dn_valid & dn_ready & ~dn_write;
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import irb_pkg::*;
#(
  parameter int HI_W = 12,
  localparam int AW = HI_W + REG_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slv_present,
  input  logic             hst_we,
  input  logic [3:0]       hst_addr,
  input  logic [REG_W-1:0] hst_wdata,
  output logic [REG_W-1:0] hst_rdata,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic             dn_write,
  output logic [AW-1:0]    dn_addr,
  output logic [REG_W-1:0] dn_wdata,
  input  logic [REG_W-1:0] dn_rdata
);
  irb_cmd_e         cmd;
  logic [SUB_W-1:0] sub_addr;
  logic [REG_W-1:0] data_q;
  logic [HI_W-1:0]  hi_q;
  logic [REG_W-1:0] lo_q;
  logic             busy_vis;
  logic             rd_done;
  logic             ctl_wr;

  assign ctl_wr = hst_we && (hst_addr == OFS_CTL);

  irb_cmd_dec u_dec (
    .ctl_word (hst_wdata),
    .cmd      (cmd),
    .sub_addr (sub_addr)
  );

  irb_regs #(.HI_W(HI_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (hst_we),
    .wr_ofs      (hst_addr),
    .wr_data     (hst_wdata),
    .xfer_active (dn_valid),
    .cap_en      (rd_done),
    .cap_data    (dn_rdata),
    .data_q      (data_q),
    .hi_q        (hi_q),
    .lo_q        (lo_q)
  );

  irb_xfer #(.AW(AW)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ctl_wr),
    .cmd      (cmd),
    .addr_in  ({hi_q, lo_q, sub_addr}),
    .dn_ready (dn_ready),
    .dn_valid (dn_valid),
    .dn_write (dn_write),
    .dn_addr  (dn_addr),
    .busy_vis (busy_vis),
    .rd_done  (rd_done)
  );

  assign dn_wdata = data_q;

  always_comb begin
    unique case (hst_addr)
      OFS_CTL: hst_rdata = {7'd0, busy_vis, 7'd0, slv_present};
      OFS_DAT: hst_rdata = data_q;
      OFS_HI:  hst_rdata = {{(REG_W-HI_W){1'b0}}, hi_q};
      OFS_LO:  hst_rdata = lo_q;
      default: hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irb_chk.sv
module irb_chk
  import irb_pkg::*;
#(
  parameter int AW = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hst_we,
  input logic [3:0]       hst_addr,
  input logic [REG_W-1:0] hst_wdata,
  input logic [REG_W-1:0] hst_rdata,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic             dn_write,
  input logic [AW-1:0]    dn_addr,
  input logic [REG_W-1:0] dn_wdata
);
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_write) &&
                                 $stable(dn_addr) && $stable(dn_wdata)));

  p_read_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && hst_we && hst_addr == OFS_CTL &&
     (hst_wdata & CMD_MASK) == PAT_RD)
    |=> (dn_valid && !dn_write && dn_addr[SUB_W-1:0] == $past(hst_wdata[SUB_LSB +: SUB_W])));

  p_write_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && hst_we && hst_addr == OFS_CTL &&
     (hst_wdata & CMD_MASK) == PAT_WR) |=> (dn_valid && dn_write));

  p_busy_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && hst_addr == OFS_CTL) |-> !hst_rdata[8]);

  p_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && hst_we && hst_addr == OFS_CTL &&
     (hst_wdata & CMD_MASK) != PAT_RD && (hst_wdata & CMD_MASK) != PAT_WR &&
     (hst_wdata & CMD_MASK) != PAT_DWR) |=> !dn_valid);
endmodule

bind ind_reg_bridge irb_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hst_we    (hst_we),
  .hst_addr  (hst_addr),
  .hst_wdata (hst_wdata),
  .hst_rdata (hst_rdata),
  .dn_valid  (dn_valid),
  .dn_ready  (dn_ready),
  .dn_write  (dn_write),
  .dn_addr   (dn_addr),
  .dn_wdata  (dn_wdata)
);

// File: tb/sim_ind_reg_bridge.sv
`timescale 1ns/1ps
module sim_ind_reg_bridge;
  localparam int AW = 31;
  localparam logic [3:0] A_CTL = 4'h0, A_DAT = 4'h4, A_HI = 4'h8, A_LO = 4'hA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slv_present = 1'b1;
  logic hst_we = 1'b0;
  logic [3:0] hst_addr = 4'h0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic dn_valid, dn_write;
  logic dn_ready = 1'b0;
  logic [AW-1:0] dn_addr;
  logic [15:0] dn_wdata;
  logic [15:0] dn_rdata = '0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ind_reg_bridge u0 (
    .clk(clk), .rst_n(rst_n), .slv_present(slv_present),
    .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [15:0] hi, lo, input logic [2:0] sub);
    return {hi[11:0], lo, sub};
  endfunction

  function automatic logic [15:0] cmd_word(input int kind, input logic [2:0] sub);
    logic [15:0] b;
    b = (kind == 0) ? 16'h0101 : (kind == 1) ? 16'h3101 : 16'h3001;
    return b | (16'(sub) << 9);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] a, input logic [15:0] d);
    hst_addr = a; hst_wdata = d; hst_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [15:0] v);
    hst_addr = a;
    #1;
    v = hst_rdata;
  endtask

  task automatic do_xfer(input int kind, input logic [2:0] sub,
                         input logic [15:0] hi, lo, dat, rdat, input int lat);
    logic [15:0] v;
    logic [AW-1:0] ea;
    ea = exp_addr(hi, lo, sub);
    hwr(A_HI, hi); hwr(A_LO, lo); hwr(A_DAT, dat);
    hwr(A_CTL, cmd_word(kind, sub));
    chk(dn_valid == 1'b1, "R3 valid after command", 32'(dn_valid), 1);
    chk(dn_addr == ea, "R3 address composition", 32'(dn_addr), 32'(ea));
    chk(dn_write == (kind != 0), "R4 direction", 32'(dn_write), 32'(kind != 0));
    if (kind != 0) chk(dn_wdata == dat, "R4 write data", 32'(dn_wdata), 32'(dat));
    hrd(A_CTL, v);
    if (kind == 2) chk(v == 16'h0001, "R6 direct write no busy", 32'(v), 32'h1);
    else chk(v == 16'h0101, "R5 busy shown", 32'(v), 32'h101);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(dn_valid && dn_addr == ea, "R7 request held", 32'(dn_addr), 32'(ea));
    end
    dn_ready = 1'b1; dn_rdata = rdat;
    @(negedge clk);
    dn_ready = 1'b0;
    chk(dn_valid == 1'b0, "R5 request done", 32'(dn_valid), 0);
    hrd(A_CTL, v);
    chk(v == 16'h0001, "R5 busy cleared", 32'(v), 32'h1);
    hrd(A_DAT, v);
    chk(v == ((kind == 0) ? rdat : dat), "R5 data register", 32'(v),
        32'((kind == 0) ? rdat : dat));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    hrd(A_CTL, v); chk(v == 16'h0001, "R1 control reset", 32'(v), 32'h1);
    hrd(A_DAT, v); chk(v == 16'h0, "R1 data reset", 32'(v), 0);
    hrd(A_HI, v);  chk(v == 16'h0, "R1 high reset", 32'(v), 0);
    hrd(A_LO, v);  chk(v == 16'h0, "R1 low reset", 32'(v), 0);
    chk(dn_valid == 1'b0, "R1 no request in reset", 32'(dn_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    slv_present = 1'b0;
    hrd(A_CTL, v); chk(v == 16'h0000, "R1 absent slave", 32'(v), 0);
    slv_present = 1'b1;

    hwr(A_HI, 16'hFABC); hrd(A_HI, v); chk(v == 16'h0ABC, "R2 high 12 bits", 32'(v), 32'hABC);
    hwr(A_LO, 16'h1357); hrd(A_LO, v); chk(v == 16'h1357, "R2 low", 32'(v), 32'h1357);
    hwr(A_DAT, 16'hBEEF); hrd(A_DAT, v); chk(v == 16'hBEEF, "R2 data", 32'(v), 32'hBEEF);

    hwr(A_CTL, 16'h0100);
    chk(dn_valid == 1'b0, "R9 bit0 clear pattern", 32'(dn_valid), 0);
    hwr(A_CTL, 16'h3103);
    chk(dn_valid == 1'b0, "R9 extra bit pattern", 32'(dn_valid), 0);
    hwr(A_CTL, 16'h2001);
    chk(dn_valid == 1'b0, "R9 near direct pattern", 32'(dn_valid), 0);

    do_xfer(0, 3'd5, 16'h0123, 16'h4567, 16'h0, 16'hA5A5, 3);
    do_xfer(1, 3'd7, 16'h0FFF, 16'hFFFF, 16'h9876, 16'h0, 0);
    do_xfer(2, 3'd0, 16'h0001, 16'h0000, 16'h5555, 16'h0, 2);

    hwr(A_HI, 16'h0001); hwr(A_LO, 16'h0002); hwr(A_DAT, 16'h1111);
    hwr(A_CTL, cmd_word(1, 3'd1));
    hwr(A_CTL, cmd_word(0, 3'd7));
    chk(dn_addr == exp_addr(16'h1, 16'h2, 3'd1) && dn_write, "R8 busy command ignored",
        32'(dn_addr), 32'(exp_addr(16'h1, 16'h2, 3'd1)));
    hwr(A_DAT, 16'h2222);
    chk(dn_wdata == 16'h1111, "R10 wdata kept", 32'(dn_wdata), 32'h1111);
    hwr(A_HI, 16'h00FF);
    chk(dn_addr == exp_addr(16'h1, 16'h2, 3'd1), "R11 address kept",
        32'(dn_addr), 32'(exp_addr(16'h1, 16'h2, 3'd1)));
    hrd(A_HI, v); chk(v == 16'h00FF, "R11 high register updated", 32'(v), 32'hFF);
    dn_ready = 1'b1;
    @(negedge clk);
    dn_ready = 1'b0;
    @(negedge clk);
    chk(dn_valid == 1'b0, "R8 no queued request", 32'(dn_valid), 0);
    hrd(A_DAT, v); chk(v == 16'h1111, "R10 data register kept", 32'(v), 32'h1111);

    for (int k = 0; k < 40; k++) begin
      do_xfer(int'($urandom_range(0, 2)), 3'($urandom), 16'($urandom), 16'($urandom),
              16'($urandom), 16'($urandom), int'($urandom_range(0, 5)));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule